// File: doc/BRIEF.md
# Bit-Interleaved SECDED Storage Array

This block is a small register-file style storage array whose every 64-bit word is kept as a 72-bit extended Hamming codeword. The codewords are single-error-correcting and double-error-detecting. Each physical row holds `ILV` codewords, and their bits are woven together column by column. Two cells that sit side by side in a row therefore always belong to different codewords. A particle strike that upsets a short run of neighbouring cells then appears as one correctable error in each of several words. It does not appear as an uncorrectable double error in a single word.

The write port encodes every lane of the incoming row and scatters the codeword bits into physical columns. The read port takes a row address and returns, one clock later, the gathered, checked and corrected data for every lane. Each lane also has a correctable-error flag and an uncorrectable-error flag. A fault-injection port XORs a column mask into a stored row without re-encoding it. This allows single, double and burst upsets to be planted on purpose.

Top module: `ilv_ecc_array`

## Requirements
- R1: Each lane codeword is 72 bits with positions 0..71. Position 0 holds the even parity of positions 1..71. Positions 1, 2, 4, 8, 16, 32 and 64 hold the Hamming checks: check at position 2^i is the XOR of all positions with bit i set. The data bits fill the remaining positions in ascending order, with data bit 0 at position 3. A row written and read back without injection returns the written data with both flags of every lane low.
- R2: Read data and flags appear registered one clock after the read address is presented. A read and a write to the same row in the same cycle return the row's contents from before the write.
- R3: Physical column c of a row holds codeword position c / ILV of lane c mod ILV. Lane l carries write and read data bits [64*l+63 : 64*l].
- R4: A single flipped bit at any position 1..71 of a lane's codeword is corrected on read, and that lane's correctable flag is set. All other lanes stay clean.
- R5: A flip of only the overall parity bit (position 0) sets the correctable flag and returns the data unchanged.
- R6: Two flipped bits in one lane's codeword set that lane's uncorrectable flag and clear its correctable flag. The lane's data is returned uncorrected: a flipped data position appears inverted in the output.
- R7: A burst of ILV adjacent flipped columns anywhere in a row is fully corrected, with the correctable flag set in every lane.
- R8: An injection XORs its mask into the stored row without re-encoding, and the change persists across reads. Injecting the same mask a second time restores a clean row.
- R9: When a write and an injection hit the same row in the same cycle, the stored row is the newly encoded row XOR the mask. When they hit different rows, both take effect.
- R10: While reset is asserted, the read data and both flag vectors are zero.
- R11: For any lane, the correctable and uncorrectable flags are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the read output registers |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | $clog2(DEPTH) | Write row address |
| wr_data_i | input | 64*ILV | Write data, lane l in bits [64*l+63:64*l] |
| rd_addr_i | input | $clog2(DEPTH) | Read row address, sampled every cycle |
| rd_data_o | output | 64*ILV | Corrected read data |
| rd_ce_o | output | ILV | Per-lane correctable error seen |
| rd_ue_o | output | ILV | Per-lane uncorrectable error |
| inj_en_i | input | 1 | Fault-injection strobe |
| inj_addr_i | input | $clog2(DEPTH) | Row to corrupt |
| inj_mask_i | input | 72*ILV | Physical column mask XORed into the row |

## Verification
The round-trip property assumes that any row it reads was written at least once since power-up, because the array itself is not reset. It also assumes that no injection touched the row in the write cycle. The stability property assumes that the read address is held and that there is no write or injection traffic in between.

The stimulus writes every row before it reads any row. Every injection is paired with a second, identical injection so that the row is restored before the next case. Injections are kept apart from the writes except in the one test that deliberately overlaps them.

// File: rtl/ilv_ecc_pkg.sv
package ilv_ecc_pkg;
  localparam int DATA_W = 64;
  localparam int CW_W   = 72;
  localparam int SYN_W  = 7;

  function automatic bit is_chk_pos(int p);
    return (p == 0) || ((p & (p - 1)) == 0);
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import ilv_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  logic [CW_W-1:0]  cw;
  logic [SYN_W-1:0] syn;

  always_comb begin
    int k;
    cw  = '0;
    syn = '0;
    k   = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_chk_pos(p)) begin
        cw[p] = data_i[k];
        k++;
      end
    end
    for (int p = 1; p < CW_W; p++) begin
      if (cw[p]) syn = syn ^ SYN_W'(p);
    end
    for (int i = 0; i < SYN_W; i++) cw[1 << i] = syn[i];
    cw[0] = ^cw[CW_W-1:1];
  end

  assign cw_o = cw;
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ilv_ecc_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ce_o,
  output logic              ue_o
);
  logic [SYN_W-1:0] syn;
  logic             par_odd;
  logic             syn_ok;
  logic [CW_W-1:0]  fixed;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (cw_i[p]) syn = syn ^ SYN_W'(p);
    end
  end

  assign par_odd = ^cw_i;
  // syndrome beyond the last position cannot come from a single flip
  assign syn_ok  = (syn <= SYN_W'(CW_W - 1));

  always_comb begin
    fixed = cw_i;
    if (par_odd && syn_ok && (syn != '0)) fixed[syn] = ~cw_i[syn];
  end

  always_comb begin
    int k;
    data_o = '0;
    k      = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_chk_pos(p)) begin
        data_o[k] = fixed[p];
        k++;
      end
    end
  end

  assign ce_o = par_odd && syn_ok;
  assign ue_o = (!par_odd && (syn != '0)) || (par_odd && !syn_ok);
endmodule

// File: rtl/ilv_map.sv
module ilv_map
  import ilv_ecc_pkg::*;
#(
  parameter int ILV    = 4,
  parameter bit GATHER = 1'b0,
  localparam int ROW_W = ILV * CW_W
) (
  input  logic [ROW_W-1:0] src_i,
  output logic [ROW_W-1:0] dst_o
);
  for (genvar c = 0; c < ROW_W; c++) begin : g_col
    localparam int LANE = c % ILV;
    localparam int POS  = c / ILV;
    if (GATHER) begin : g_gather
      assign dst_o[LANE*CW_W + POS] = src_i[c];
    end else begin : g_scatter
      assign dst_o[c] = src_i[LANE*CW_W + POS];
    end
  end
endmodule

// File: rtl/ilv_row_store.sv
module ilv_row_store #(
  parameter int ROW_W = 288,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic             inj_en_i,
  input  logic [AW-1:0]    inj_addr_i,
  input  logic [ROW_W-1:0] inj_mask_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [ROW_W-1:0] rd_row_o
);
  logic [ROW_W-1:0] mem [DEPTH];
  logic             hit;
  logic [ROW_W-1:0] wr_flip;

  assign hit     = wr_en_i && inj_en_i && (wr_addr_i == inj_addr_i);
  assign wr_flip = hit ? inj_mask_i : '0;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_row_i ^ wr_flip;
    if (inj_en_i && !hit) mem[inj_addr_i] <= mem[inj_addr_i] ^ inj_mask_i;
  end

  assign rd_row_o = mem[rd_addr_i];
endmodule

// File: rtl/ilv_ecc_array.sv
module ilv_ecc_array
  import ilv_ecc_pkg::*;
#(
  parameter int ILV   = 4,
  parameter int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = ILV * DATA_W,
  localparam int ROW_W = ILV * CW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [ILV-1:0]   rd_ce_o,
  output logic [ILV-1:0]   rd_ue_o,
  input  logic             inj_en_i,
  input  logic [AW-1:0]    inj_addr_i,
  input  logic [ROW_W-1:0] inj_mask_i
);
  logic [ROW_W-1:0] wr_lanes, wr_row, rd_row, rd_lanes;
  logic [DW-1:0]    dec_data;
  logic [ILV-1:0]   dec_ce, dec_ue;

  for (genvar l = 0; l < ILV; l++) begin : g_lane
    secded_enc u_enc (
      .data_i (wr_data_i[l*DATA_W +: DATA_W]),
      .cw_o   (wr_lanes[l*CW_W +: CW_W])
    );
    secded_dec u_dec (
      .cw_i   (rd_lanes[l*CW_W +: CW_W]),
      .data_o (dec_data[l*DATA_W +: DATA_W]),
      .ce_o   (dec_ce[l]),
      .ue_o   (dec_ue[l])
    );
  end

  ilv_map #(.ILV(ILV), .GATHER(1'b0)) u_scatter (.src_i(wr_lanes), .dst_o(wr_row));
  ilv_map #(.ILV(ILV), .GATHER(1'b1)) u_gather  (.src_i(rd_row),   .dst_o(rd_lanes));

  ilv_row_store #(.ROW_W(ROW_W), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_row_i   (wr_row),
    .inj_en_i   (inj_en_i),
    .inj_addr_i (inj_addr_i),
    .inj_mask_i (inj_mask_i),
    .rd_addr_i  (rd_addr_i),
    .rd_row_o   (rd_row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      rd_ce_o   <= '0;
      rd_ue_o   <= '0;
    end else begin
      rd_data_o <= dec_data;
      rd_ce_o   <= dec_ce;
      rd_ue_o   <= dec_ue;
    end
  end
endmodule

// File: rtl/ilv_ecc_array_chk.sv
module ilv_ecc_array_chk
  import ilv_ecc_pkg::*;
#(
  parameter int ILV   = 4,
  parameter int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = ILV * DATA_W,
  localparam int ROW_W = ILV * CW_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [AW-1:0]    rd_addr_i,
  input logic [DW-1:0]    rd_data_o,
  input logic [ILV-1:0]   rd_ce_o,
  input logic [ILV-1:0]   rd_ue_o,
  input logic             inj_en_i,
  input logic [AW-1:0]    inj_addr_i,
  input logic [ROW_W-1:0] inj_mask_i
);
  logic [1:0] warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R11
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ce_o & rd_ue_o) == '0);

  // R10
  reset_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rd_data_o == '0 && rd_ce_o == '0 && rd_ue_o == '0));

  // R1
  roundtrip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2 && $past(wr_en_i) && !$past(inj_en_i) && rd_addr_i == $past(wr_addr_i))
    |=> (rd_data_o == $past(wr_data_i, 2) && rd_ce_o == '0 && rd_ue_o == '0));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2 && rd_addr_i == $past(rd_addr_i) && !$past(wr_en_i) && !$past(inj_en_i))
    |=> ($stable(rd_data_o) && $stable(rd_ce_o) && $stable(rd_ue_o)));
endmodule

bind ilv_ecc_array ilv_ecc_array_chk #(.ILV(ILV), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .rd_ce_o    (rd_ce_o),
  .rd_ue_o    (rd_ue_o),
  .inj_en_i   (inj_en_i),
  .inj_addr_i (inj_addr_i),
  .inj_mask_i (inj_mask_i)
);

// File: tb/ilv_ecc_array_bench.sv
module ilv_ecc_array_bench;
  localparam int ILV   = 4;
  localparam int DEPTH = 8;
  localparam int AW    = 3;
  localparam int DW    = ILV * 64;
  localparam int ROW_W = ILV * 72;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [DW-1:0]    wr_data = '0;
  logic [AW-1:0]    rd_addr = '0;
  logic [DW-1:0]    rd_data;
  logic [ILV-1:0]   rd_ce, rd_ue;
  logic             inj_en = 1'b0;
  logic [AW-1:0]    inj_addr = '0;
  logic [ROW_W-1:0] inj_mask = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  ilv_ecc_array #(.ILV(ILV), .DEPTH(DEPTH)) u_ilv_ecc_array (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_ce_o(rd_ce), .rd_ue_o(rd_ue),
    .inj_en_i(inj_en), .inj_addr_i(inj_addr), .inj_mask_i(inj_mask)
  );

  function automatic int data_idx(int p);
    int n;
    if (p == 0 || (p & (p - 1)) == 0) return -1;
    n = 0;
    for (int q = 1; q <= p; q++) if ((q & (q - 1)) == 0) n++;
    return p - 1 - n;
  endfunction

  function automatic logic [DW-1:0] pattern(int a, int s);
    logic [DW-1:0] v;
    for (int l = 0; l < ILV; l++)
      v[l*64 +: 64] = 64'h9E37_79B9_7F4A_7C15 * (a * 7 + l * 3 + s + 1) ^ {32'(s), 32'(a)};
    return v;
  endfunction

  task automatic chk(string req, logic [DW-1:0] exp_d, logic [ILV-1:0] exp_ce, logic [ILV-1:0] exp_ue);
    n_run++;
    if (rd_data !== exp_d || rd_ce !== exp_ce || rd_ue !== exp_ue || (rd_ce & rd_ue) != '0) begin
      n_fail++;
      $display("FAIL %s: data=%h ce=%b ue=%b expected data=%h ce=%b ue=%b",
               req, rd_data, rd_ce, rd_ue, exp_d, exp_ce, exp_ue);
    end
  endtask

  task automatic do_write(int a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; inj_en = 1'b0;
    model[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_inj(int a, logic [ROW_W-1:0] m);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = AW'(a); inj_mask = m; wr_en = 1'b0;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic do_read(int a);
    @(negedge clk);
    rd_addr = AW'(a); wr_en = 1'b0; inj_en = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset", '0, '0, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: all rows, several patterns
    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < DEPTH; a++)
        do_write(a, s == 0 ? '0 : (s == 1 ? '1 : pattern(a, s)));
      for (int a = 0; a < DEPTH; a++) begin
        do_read(a);
        chk("R1 roundtrip", model[a], '0, '0);
      end
    end

    // R2: read-first on same-cycle write, then new data
    @(negedge clk);
    rd_addr = '0; wr_en = 1'b1; wr_addr = '0; wr_data = pattern(9, 9);
    @(posedge clk);
    #1;
    chk("R2 read-first", model[0], '0, '0);
    model[0] = pattern(9, 9);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk);
    #1;
    chk("R2 new data", model[0], '0, '0);

    // R3 R4 R5: every single column of row 3
    for (int l = 0; l < ILV; l++) begin
      for (int p = 0; p < 72; p++) begin
        logic [ROW_W-1:0] m;
        m = '0; m[p*ILV + l] = 1'b1;
        do_inj(3, m);
        do_read(3);
        chk(p == 0 ? "R5 parity flip" : "R4 R3 single flip", model[3], ILV'(1) << l, '0);
        do_inj(3, m);
      end
    end

    // R6: adjacent codeword positions in one lane
    for (int l = 0; l < ILV; l++) begin
      for (int p = 0; p < 71; p++) begin
        logic [ROW_W-1:0] m;
        logic [DW-1:0] e;
        m = '0; m[p*ILV + l] = 1'b1; m[(p+1)*ILV + l] = 1'b1;
        e = model[4];
        if (data_idx(p) >= 0)     e[l*64 + data_idx(p)]     = ~e[l*64 + data_idx(p)];
        if (data_idx(p + 1) >= 0) e[l*64 + data_idx(p + 1)] = ~e[l*64 + data_idx(p + 1)];
        do_inj(4, m);
        do_read(4);
        chk("R6 double flip", e, '0, ILV'(1) << l);
        do_inj(4, m);
      end
    end

    // R7: bursts of ILV adjacent columns
    for (int c = 0; c <= ROW_W - ILV; c++) begin
      logic [ROW_W-1:0] m;
      m = '0;
      for (int k = 0; k < ILV; k++) m[c + k] = 1'b1;
      do_inj(2, m);
      do_read(2);
      chk("R7 burst", model[2], '1, '0);
      do_inj(2, m);
    end

    // R8: persistence and restore
    begin
      logic [ROW_W-1:0] m;
      m = '0; m[20*ILV + 1] = 1'b1;
      do_inj(1, m);
      do_read(1);
      chk("R8 first read", model[1], 4'b0010, '0);
      do_read(1);
      chk("R8 persists", model[1], 4'b0010, '0);
      do_inj(1, m);
      do_read(1);
      chk("R8 restored", model[1], '0, '0);
    end

    // R9: write and inject same row, then different rows
    begin
      logic [ROW_W-1:0] m;
      m = '0; m[10*ILV + 2] = 1'b1;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd5; wr_data = pattern(5, 7); model[5] = pattern(5, 7);
      inj_en = 1'b1; inj_addr = 3'd5; inj_mask = m;
      @(negedge clk);
      wr_en = 1'b0; inj_en = 1'b0;
      do_read(5);
      chk("R9 same row", model[5], 4'b0100, '0);
      m = '0; m[1] = 1'b1;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd5; wr_data = pattern(5, 8); model[5] = pattern(5, 8);
      inj_en = 1'b1; inj_addr = 3'd6; inj_mask = m;
      @(negedge clk);
      wr_en = 1'b0; inj_en = 1'b0;
      do_read(5);
      chk("R9 write other row", model[5], '0, '0);
      do_read(6);
      chk("R9 inject other row", model[6], 4'b0010, '0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule